// File: doc/BRIEF.md
# SPI Offload Command Replay Controller

This block holds a preloaded sequence of SPI command words and a matching sequence of transmit-data words. Each external trigger replays both sequences toward a serial engine. Software fills the two stores through separate write strobes while the block is idle. A clear strobe empties both stores. An enable input arms the trigger.

During a replay, command words leave in write order on a valid/ready stream. Transmit-data words leave in write order on a second valid/ready stream, and the engine pulls them at its own pace. The replay ends when two things have happened: the engine has accepted the last stored command, and it has returned an end-of-transfer acknowledge. The status output `enabled` is high whenever `enable` is high. After `enable` falls, it stays high until the replay in flight has finished. While `enabled` is high, the stores ignore all writes and clears.

Each store holds a fixed number of entries. A write to a full store is dropped and sets a sticky overflow flag. The flag stays set until the next accepted clear.

Top module: `spi_replay_ctrl`

## Requirements
- R1: While `enabled` is low, a command write appends `cmd_wr_data` at the next free position. A replay presents the stored command words on `cmd_data` in write order, starting from the first, and issues exactly as many command beats as were written since the last clear.
- R2: SDO writes fill their own store, with a write position that is independent of the command store. A replay offers the stored SDO words on `sdo_data` in write order. `sdo_valid` is high only while a replay is active and unsent SDO words remain.
- R3: An accepted `mem_clear` empties both stores and clears both overflow flags. A clear in the same cycle as a write takes priority over the write.
- R4: While `enable` is high and no replay is active, a `trigger` starts a replay if the command store is non-empty. `cmd_valid` rises in the cycle after the trigger.
- R5: While `enable` is low, `trigger` has no effect and no replay starts.
- R6: A trigger during an active replay is ignored and is not held for later.
- R7: `enabled` equals `enable` OR replay-active. After `enable` falls during a replay, `enabled` stays high until that replay completes.
- R8: While `enabled` is high, command writes, SDO writes and `mem_clear` are dropped, so the stored contents and lengths are unchanged.
- R9: A write to a full store (DEPTH entries) is dropped and sets that store's sticky overflow flag (`cmd_ovf` or `sdo_ovf`). The flag stays high until an accepted clear. No store holds more than DEPTH entries.
- R10: A replay completes in the cycle after `eot_ack` is high, provided the last command has already been accepted. Both read positions then return to the start, ready for the next trigger.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_data` is held.
- R12: A trigger while the command store is empty starts no replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Append strobe for the command store |
| cmd_wr_data | input | CMD_W | Command word to append |
| sdo_wr_en | input | 1 | Append strobe for the SDO store |
| sdo_wr_data | input | SDO_W | SDO word to append |
| mem_clear | input | 1 | Empty both stores |
| enable | input | 1 | Arm the trigger |
| trigger | input | 1 | External start event |
| enabled | output | 1 | Armed or replay in progress |
| cmd_valid | output | 1 | Command word offered |
| cmd_ready | input | 1 | Engine takes the command word |
| cmd_data | output | CMD_W | Offered command word |
| sdo_valid | output | 1 | SDO word offered |
| sdo_ready | input | 1 | Engine takes the SDO word |
| sdo_data | output | SDO_W | Offered SDO word |
| eot_ack | input | 1 | Engine reports end of transfer |
| cmd_ovf | output | 1 | Sticky command-store overflow |
| sdo_ovf | output | 1 | Sticky SDO-store overflow |

## Verification
Replays run under three ready patterns. Always-ready checks the beat count and the word order. Toggling command-ready with sparse SDO-ready tells a design that holds its offered word apart from one that skips or repeats words. A delayed end-of-transfer acknowledge shows whether completion waits for the engine. Triggers are repeated during a replay and sent while disarmed to separate ignored triggers from queued ones. In a further run, `enable` falls mid-replay while writes and a clear are attempted, which shows whether the status holds and the stores stay locked. Filling a store past its depth and then clearing it checks saturation and the sticky flag.

// File: rtl/spi_replay_pkg.sv
package spi_replay_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_STREAM = 2'd1,
        PH_DRAIN  = 2'd2
    } phase_e;

    typedef struct packed {
        logic valid;
        logic ready;
    } hs_t;

    function automatic logic hs_fire(hs_t h);
        return h.valid && h.ready;
    endfunction

    function automatic logic final_beat(int unsigned rd, int unsigned cnt);
        return (rd + 1) == cnt;
    endfunction

endpackage

// File: rtl/replay_store.sv
module replay_store #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lock,
    input  logic            clear,
    input  logic            wr_en,
    input  logic [W-1:0]    wr_data,
    input  logic [CNTW-1:0] rd_pos,
    output logic [W-1:0]    rd_data,
    output logic [CNTW-1:0] fill,
    output logic            ovf
);

    logic [W-1:0] mem [DEPTH];
    logic         room;
    logic         do_write;

    assign room     = fill < CNTW'(DEPTH);
    assign do_write = !lock && !clear && wr_en && room;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
            ovf  <= 1'b0;
        end else if (!lock) begin
            if (clear) begin
                fill <= '0;
                ovf  <= 1'b0;
            end else if (wr_en) begin
                if (room) fill <= fill + 1'b1;
                else      ovf  <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_write) mem[fill[IW-1:0]] <= wr_data;
    end

    assign rd_data = mem[rd_pos[IW-1:0]];

endmodule

// File: rtl/replay_sequencer.sv
module replay_sequencer
    import spi_replay_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            trigger,
    input  logic [CNTW-1:0] cmd_fill,
    input  logic [CNTW-1:0] sdo_fill,
    input  logic            cmd_ready,
    input  logic            sdo_ready,
    input  logic            eot_ack,
    output logic            busy,
    output logic            cmd_valid,
    output logic            sdo_valid,
    output logic [CNTW-1:0] cmd_pos,
    output logic [CNTW-1:0] sdo_pos
);

    phase_e phase;
    hs_t    cmd_hs, sdo_hs;
    logic   start;

    assign busy      = phase != PH_IDLE;
    assign cmd_valid = phase == PH_STREAM;
    assign sdo_valid = busy && (sdo_pos < sdo_fill);
    assign cmd_hs    = '{valid: cmd_valid, ready: cmd_ready};
    assign sdo_hs    = '{valid: sdo_valid, ready: sdo_ready};
    assign start     = enable && trigger && (cmd_fill != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cmd_pos <= '0;
            sdo_pos <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    cmd_pos <= '0;
                    sdo_pos <= '0;
                    if (start) phase <= PH_STREAM;
                end
                PH_STREAM: begin
                    if (hs_fire(cmd_hs)) begin
                        if (final_beat(32'(cmd_pos), 32'(cmd_fill))) phase <= PH_DRAIN;
                        else cmd_pos <= cmd_pos + 1'b1;
                    end
                    if (hs_fire(sdo_hs)) sdo_pos <= sdo_pos + 1'b1;
                end
                PH_DRAIN: begin
                    if (hs_fire(sdo_hs)) sdo_pos <= sdo_pos + 1'b1;
                    if (eot_ack) begin
                        phase   <= PH_IDLE;
                        cmd_pos <= '0;
                        sdo_pos <= '0;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_replay_ctrl.sv
module spi_replay_ctrl #(
    parameter int DEPTH = 16,
    parameter int CMD_W = 16,
    parameter int SDO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr_en,
    input  logic [CMD_W-1:0] cmd_wr_data,
    input  logic             sdo_wr_en,
    input  logic [SDO_W-1:0] sdo_wr_data,
    input  logic             mem_clear,
    input  logic             enable,
    input  logic             trigger,
    output logic             enabled,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [CMD_W-1:0] cmd_data,
    output logic             sdo_valid,
    input  logic             sdo_ready,
    output logic [SDO_W-1:0] sdo_data,
    input  logic             eot_ack,
    output logic             cmd_ovf,
    output logic             sdo_ovf
);

    localparam int CNTW = $clog2(DEPTH + 1);

    logic            busy;
    logic            lock;
    logic [CNTW-1:0] cmd_count, sdo_count;
    logic [CNTW-1:0] cmd_pos, sdo_pos;

    assign enabled = enable || busy;
    assign lock    = enabled;

    replay_store #(.DEPTH(DEPTH), .W(CMD_W)) u_cmd_store (
        .clk(clk), .rst(rst), .lock(lock), .clear(mem_clear),
        .wr_en(cmd_wr_en), .wr_data(cmd_wr_data),
        .rd_pos(cmd_pos), .rd_data(cmd_data),
        .fill(cmd_count), .ovf(cmd_ovf)
    );

    replay_store #(.DEPTH(DEPTH), .W(SDO_W)) u_sdo_store (
        .clk(clk), .rst(rst), .lock(lock), .clear(mem_clear),
        .wr_en(sdo_wr_en), .wr_data(sdo_wr_data),
        .rd_pos(sdo_pos), .rd_data(sdo_data),
        .fill(sdo_count), .ovf(sdo_ovf)
    );

    replay_sequencer #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst), .enable(enable), .trigger(trigger),
        .cmd_fill(cmd_count), .sdo_fill(sdo_count),
        .cmd_ready(cmd_ready), .sdo_ready(sdo_ready), .eot_ack(eot_ack),
        .busy(busy), .cmd_valid(cmd_valid), .sdo_valid(sdo_valid),
        .cmd_pos(cmd_pos), .sdo_pos(sdo_pos)
    );

endmodule

// File: rtl/replay_chk.sv
module replay_chk #(
    parameter int DEPTH = 16,
    parameter int CMD_W = 16,
    parameter int CNTW  = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             enabled,
    input logic             mem_clear,
    input logic             eot_ack,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [CMD_W-1:0] cmd_data,
    input logic             cmd_ovf,
    input logic [CNTW-1:0]  cmd_cnt,
    input logic [CNTW-1:0]  sdo_cnt
);

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

    // R7
    enabled_follow_chk: assert property (@(posedge clk) disable iff (rst)
        enable |-> enabled);

    // R5
    disarmed_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !enable && !enabled |=> !cmd_valid);

    // R8
    locked_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        enabled |=> $stable(cmd_cnt));

    // R8
    locked_sdo_chk: assert property (@(posedge clk) disable iff (rst)
        enabled |=> $stable(sdo_cnt));

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ovf && !(mem_clear && !enabled) |=> cmd_ovf);

    // R9
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_cnt <= CNTW'(DEPTH) && sdo_cnt <= CNTW'(DEPTH));

    // R10
    eot_done_chk: assert property (@(posedge clk) disable iff (rst)
        enabled && !enable && !cmd_valid && eot_ack |=> !enabled);

endmodule

bind spi_replay_ctrl replay_chk #(.DEPTH(DEPTH), .CMD_W(CMD_W), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst(rst), .enable(enable), .enabled(enabled),
    .mem_clear(mem_clear), .eot_ack(eot_ack),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_ovf(cmd_ovf), .cmd_cnt(cmd_count), .sdo_cnt(sdo_count)
);

// File: tb/spi_replay_ctrl_tb.sv
module spi_replay_ctrl_tb;

    localparam int DEPTH = 16;
    localparam int CMD_W = 16;
    localparam int SDO_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_wr_en = 0, sdo_wr_en = 0, mem_clear = 0, enable = 0, trigger = 0;
    logic [CMD_W-1:0] cmd_wr_data = '0;
    logic [SDO_W-1:0] sdo_wr_data = '0;
    logic cmd_ready = 0, sdo_ready = 0, eot_ack = 0;
    logic enabled, cmd_valid, sdo_valid, cmd_ovf, sdo_ovf;
    logic [CMD_W-1:0] cmd_data;
    logic [SDO_W-1:0] sdo_data;

    always #5 clk = ~clk;

    spi_replay_ctrl #(.DEPTH(DEPTH), .CMD_W(CMD_W), .SDO_W(SDO_W)) u_dut (
        .clk(clk), .rst(rst),
        .cmd_wr_en(cmd_wr_en), .cmd_wr_data(cmd_wr_data),
        .sdo_wr_en(sdo_wr_en), .sdo_wr_data(sdo_wr_data),
        .mem_clear(mem_clear), .enable(enable), .trigger(trigger),
        .enabled(enabled), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .sdo_valid(sdo_valid), .sdo_ready(sdo_ready),
        .sdo_data(sdo_data), .eot_ack(eot_ack),
        .cmd_ovf(cmd_ovf), .sdo_ovf(sdo_ovf)
    );

    // behavioural reference state
    int cmd_q[$];
    int sdo_q[$];
    bit m_cmd_ovf, m_sdo_ovf;
    int phase, crd, srd;
    int n_checks, n_fail, cyc, beats;

    task automatic chk(string tag, longint got, longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    task automatic tick();
        bit ev, cv, sv;
        #1;
        ev = enable || (phase != 0);
        cv = (phase == 1);
        sv = (phase != 0) && (srd < sdo_q.size());
        chk("R7 enabled", enabled, ev);
        chk("R4 cmd_valid", cmd_valid, cv);
        chk("R2 sdo_valid", sdo_valid, sv);
        if (cv) chk("R1 cmd_data", cmd_data, cmd_q[crd]);
        if (sv) chk("R2 sdo_data", sdo_data, sdo_q[srd]);
        chk("R9 cmd_ovf", cmd_ovf, m_cmd_ovf);
        chk("R9 sdo_ovf", sdo_ovf, m_sdo_ovf);
        @(posedge clk);
        cyc++;
        if (cv && cmd_ready) beats++;
        if (!ev) begin
            if (mem_clear) begin
                cmd_q.delete(); sdo_q.delete();
                m_cmd_ovf = 0; m_sdo_ovf = 0;
            end else begin
                if (cmd_wr_en) begin
                    if (cmd_q.size() < DEPTH) cmd_q.push_back(int'(cmd_wr_data));
                    else m_cmd_ovf = 1;
                end
                if (sdo_wr_en) begin
                    if (sdo_q.size() < DEPTH) sdo_q.push_back(int'(sdo_wr_data));
                    else m_sdo_ovf = 1;
                end
            end
        end
        if (sv && sdo_ready) srd++;
        case (phase)
            0: if (enable && trigger && cmd_q.size() > 0) begin
                   phase = 1; crd = 0; srd = 0;
               end
            1: if (cmd_ready) begin
                   if (crd == cmd_q.size() - 1) phase = 2;
                   else crd++;
               end
            default: if (eot_ack) begin
                   phase = 0; crd = 0; srd = 0;
               end
        endcase
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cmd_wr_en = 0; sdo_wr_en = 0; mem_clear = 0; trigger = 0;
        cmd_ready = 0; sdo_ready = 0; eot_ack = 0;
    endtask

    task automatic put_cmd(int v);
        cmd_wr_en = 1; cmd_wr_data = CMD_W'(v); tick(); cmd_wr_en = 0;
    endtask

    task automatic put_sdo(int v);
        sdo_wr_en = 1; sdo_wr_data = SDO_W'(v); tick(); sdo_wr_en = 0;
    endtask

    task automatic do_clear();
        mem_clear = 1; tick(); mem_clear = 0;
    endtask

    // mode 0: always ready; mode 1: toggling ready, trigger spam, late eot;
    // mode 2: enable dropped mid-replay with write/clear attempts
    task automatic replay(int mode);
        int k, wait_eot;
        beats = 0; wait_eot = 0;
        enable = 1; trigger = 1; tick(); trigger = 0;
        for (int i = 0; i < 300 && phase != 0; i++) begin
            k = i;
            cmd_ready = (mode == 1) ? cyc[0] : 1'b1;
            sdo_ready = (mode == 1) ? (cyc % 3 == 0) : 1'b1;
            trigger   = (mode == 1) && (phase == 1);
            if (mode == 2 && k == 1) enable = 0;
            if (mode == 2 && k >= 1) begin
                cmd_wr_en = 1; cmd_wr_data = 16'hdead;
                sdo_wr_en = 1; sdo_wr_data = 8'h5a;
                mem_clear = cyc[0];
                if (mode == 2) cmd_ready = (k > 2);
            end
            if (phase == 2) wait_eot++;
            eot_ack = (phase == 2) && (wait_eot > ((mode == 0) ? 0 : 3));
            tick();
        end
        idle_inputs();
        tick();
        enable = 0;
        tick();
    endtask

    initial begin
        n_checks = 0; n_fail = 0; cyc = 0;
        phase = 0; crd = 0; srd = 0; m_cmd_ovf = 0; m_sdo_ovf = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R7 reset enabled", enabled, 0);
        chk("R4 reset cmd_valid", cmd_valid, 0);
        chk("R9 reset ovf", cmd_ovf | sdo_ovf, 0);

        // R1 R2 R4 R10: basic replay, all ready
        for (int i = 0; i < 5; i++) put_cmd(16'h1000 + i * 17);
        for (int i = 0; i < 3; i++) put_sdo(8'h40 + i);
        replay(0);
        chk("R1 beats", beats, 5);
        chk("R10 idle after eot", enabled, 0);

        // R11 R6 R10: stalls, repeated triggers, late acknowledge, re-run from start
        replay(1);
        chk("R10 second run beats", beats, 5);
        chk("R6 no queued replay", cmd_valid, 0);

        // R7 R8: disable mid-replay, writes and clears attempted while busy
        replay(2);
        chk("R8 contents kept", beats, 5);
        replay(0);
        chk("R8 length unchanged", beats, 5);

        // R5: trigger while disarmed
        trigger = 1; tick(); trigger = 0; tick();
        chk("R5 disarmed trigger", cmd_valid, 0);

        // R3 R12: clear then trigger on empty store
        cmd_wr_en = 1; cmd_wr_data = 16'h7777; mem_clear = 1; tick(); idle_inputs();
        enable = 1; trigger = 1; tick(); trigger = 0; tick();
        chk("R12 empty no start", cmd_valid, 0);
        chk("R3 empty status", enabled, 1);
        enable = 0; tick();

        // R9: overflow past depth, then clear
        for (int i = 0; i < DEPTH + 2; i++) put_cmd(16'h2000 + i);
        for (int i = 0; i < 2; i++) put_sdo(8'h90 + i);
        chk("R9 cmd ovf set", cmd_ovf, 1);
        chk("R9 sdo ovf clear", sdo_ovf, 0);
        replay(1);
        chk("R9 saturated beats", beats, DEPTH);
        chk("R9 ovf sticky", cmd_ovf, 1);
        do_clear();
        chk("R3 ovf cleared", cmd_ovf, 0);
        put_cmd(16'hbeef);
        replay(0);
        chk("R3 restart at zero", beats, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule